// File: doc/BRIEF.md
# Asynchronous Bus Cycle Master

This block turns single transfer requests from an internal port into read or write cycles on a parallel bus. The bus has a 24-bit address, a 16-bit data path and active-low strobes. It runs from a fast clock at twice the bus clock rate. Each fast-clock cycle is one half-state of the bus cycle, and the block drives the bus clock itself as a registered divide-by-two. A transfer walks through eight half-states, S0 to S7. The address and function code come out in S1 and the address strobe falls at the start of S2. On a read, the enabled data strobes fall together with the address strobe. On a write, the read/write line goes low in S2, write data is driven from S3, and the data strobes follow in S4.

The slave ends a cycle with an acknowledge input, or with a bus-error input as the alternative. Both inputs are active low and arrive asynchronously, so each passes through a two-flop synchronizer. The block looks at them at the end of S4. If neither is present, it inserts wait-state pairs and looks again at the end of each pair. Read data is sampled at the end of S6. One cycle after S7 the block returns a one-cycle response carrying the read data and an error flag.

Top module: `bus_async_master`

## Requirements
- R1: During reset and in the cycle after a synchronous reset is taken, even in the middle of a transfer, bus_as_n and all bus_ds_n bits are high, bus_rw is high, bus_dq_oe is low and rsp_valid is low.
- R2: bus_clk inverts on every clk cycle after reset. bus_as_n falls only in a cycle where bus_clk is high. At that moment bus_addr and bus_fc equal the accepted request, and they stay stable while bus_as_n is low.
- R3: On a read (req_write=0), bus_rw stays high and bus_dq_oe stays low, and the enabled data strobes fall in the same cycle as bus_as_n.
- R4: On a write, bus_rw is low from the cycle bus_as_n falls. The data strobes fall exactly 2 cycles later, with bus_dq_oe already high and bus_dq_out equal to the write data. bus_dq_oe stays high for the first cycle after bus_as_n rises and is low in the cycle after that.
- R5: bus_ds_n[i] is asserted only when req_be[i] was set; bit 1 strobes bus byte [15:8] and bit 0 strobes byte [7:0]. A data strobe is never low while bus_as_n is high. With req_be = 0 no data strobe falls, yet the transfer still ends normally.
- R6: When a terminating input is low from d cycles after bus_as_n falls, rsp_valid appears 8 + 2*ceil(d/2) cycles after the accepting clock edge. This reflects two synchronizer flops, a first look at the end of S4, and two-cycle wait pairs.
- R7: A read that ends on acknowledge alone returns in rsp_rdata the value on bus_din at the end of S6, with rsp_err = 0.
- R8: A transfer that ends on bus error alone returns rsp_err = 1 and rsp_rdata = 0.
- R9: When acknowledge and bus error are first recognized at the same sample point, bus error wins: rsp_err = 1 and rsp_rdata = 0.
- R10: req_ready is low while a transfer is in progress. Between two transfers, bus_as_n stays high for at least 2 cycles (one state pair).
- R11: rsp_valid is a single-cycle pulse, raised in the same cycle that bus_as_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request taken on this edge when req_valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Transfer address |
| req_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| req_fc | input | 3 | Function code driven with the address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Transfer ended by bus error |
| rsp_rdata | output | 16 | Read data, zero for writes and errors |
| bus_clk | output | 1 | Registered bus clock, high in even half-states |
| bus_addr | output | 24 | Bus address |
| bus_fc | output | 3 | Bus function code |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 2 | Data strobes per byte lane, active low |
| bus_rw | output | 1 | High = read, low = write |
| bus_dq_out | output | 16 | Data driven onto the bus |
| bus_dq_oe | output | 1 | Data driver enable; low releases the bus to high impedance |
| bus_din | input | 16 | Data read from the bus |
| bus_ack_n | input | 1 | Transfer acknowledge, active low, asynchronous |
| bus_berr_n | input | 1 | Bus error, active low, asynchronous |

## Verification
Acknowledge and bus error can both be recognized at the same termination sample. This decides both the error flag and whether the sampled data is returned. The bench's slave model lowers both lines on the same falling clock edge during a read whose bus_din carries a non-zero pattern. A correct response reports an error, returns zero data, and keeps the same completion latency as a plain acknowledge.

// File: rtl/bam_pkg.sv
// Shared phase encoding and phase-class decoders for the bus cycle master.
// Assumes one fast-clock cycle per bus half-state.
package bam_pkg;

    typedef enum logic [3:0] {
        PH_IDLE = 4'd0,
        PH_S0   = 4'd1,
        PH_S1   = 4'd2,
        PH_S2   = 4'd3,
        PH_S3   = 4'd4,
        PH_S4   = 4'd5,
        PH_WAIT = 4'd6,
        PH_S5   = 4'd7,
        PH_S6   = 4'd8,
        PH_S7   = 4'd9
    } bam_phase_e;

    // Half-states in which the address strobe (and read data strobes) are active.
    function automatic logic ph_as_on(bam_phase_e p);
        return (p == PH_S2) || (p == PH_S3) || (p == PH_S4) || (p == PH_WAIT) ||
               (p == PH_S5) || (p == PH_S6) || (p == PH_S7);
    endfunction

    // Half-states in which write data strobes are active.
    function automatic logic ph_wds_on(bam_phase_e p);
        return (p == PH_S4) || (p == PH_WAIT) || (p == PH_S5) ||
               (p == PH_S6) || (p == PH_S7);
    endfunction

    // Half-states in which write data is driven onto the bus.
    function automatic logic ph_dout_on(bam_phase_e p);
        return (p == PH_S3) || ph_wds_on(p);
    endfunction

endpackage

// File: rtl/bam_sync.sv
// Multi-flop synchronizer for one asynchronous level input.
// Assumes STAGES >= 2; output resets to INIT (the inactive level).
module bam_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{INIT}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/bam_seq.sv
// Half-state sequencer: steps S0..S7 one fast-clock cycle per half-state,
// inserts wait pairs after S4 until a termination is recognized, and
// produces the registered bus clock and the completion pulse.
// Assumes term_ack/term_err are already synchronized and active high.
module bam_seq
    import bam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       term_ack,
    input  logic       term_err,
    output bam_phase_e phase_q,
    output bam_phase_e phase_nx,
    output logic       req_ready,
    output logic       accept,
    output logic       err_q,
    output logic       rsp_valid,
    output logic       bus_clk
);

    logic bclk_q;
    logic term_any;

    assign term_any  = term_ack || term_err;
    assign req_ready = (phase_q == PH_IDLE) && !bclk_q;
    assign accept    = req_ready && req_valid;
    assign bus_clk   = bclk_q;

    // Next half-state selection.
    always_comb begin
        phase_nx = phase_q;
        unique case (phase_q)
            PH_IDLE: phase_nx = accept ? PH_S0 : PH_IDLE;
            PH_S0:   phase_nx = PH_S1;
            PH_S1:   phase_nx = PH_S2;
            PH_S2:   phase_nx = PH_S3;
            PH_S3:   phase_nx = PH_S4;
            PH_S4:   phase_nx = term_any ? PH_S5 : PH_WAIT;
            PH_WAIT: phase_nx = PH_S4;
            PH_S5:   phase_nx = PH_S6;
            PH_S6:   phase_nx = PH_S7;
            PH_S7:   phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register and divide-by-two bus clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            bclk_q  <= 1'b1;
        end else begin
            phase_q <= phase_nx;
            bclk_q  <= !bclk_q;
        end
    end

    // Record how the cycle ended; bus error outranks acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (accept) begin
            err_q <= 1'b0;
        end else if ((phase_q == PH_S4) && term_any) begin
            err_q <= term_err;
        end
    end

    // Completion pulse in the half-state after S7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= (phase_q == PH_S7);
        end
    end

endmodule

// File: rtl/bam_drive.sv
// Bus-side register stage: latches the accepted request, drives address,
// function code, strobes, read/write line and write data from the next
// half-state, and samples read data at the end of S6.
// Assumes phase_nx/phase_q come from bam_seq in the same clock domain.
module bam_drive
    import bam_pkg::*;
#(
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int FCW = 3,
    parameter int BEW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  bam_phase_e     phase_q,
    input  bam_phase_e     phase_nx,
    input  logic           accept,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [BEW-1:0] req_be,
    input  logic [FCW-1:0] req_fc,
    input  logic [DW-1:0]  req_wdata,
    input  logic           err_q,
    input  logic [DW-1:0]  bus_din,
    output logic [AW-1:0]  bus_addr,
    output logic [FCW-1:0] bus_fc,
    output logic           bus_as_n,
    output logic [BEW-1:0] bus_ds_n,
    output logic           bus_rw,
    output logic [DW-1:0]  bus_dq_out,
    output logic           bus_dq_oe,
    output logic [DW-1:0]  rsp_rdata
);

    logic           wr_q;
    logic [BEW-1:0] be_q;
    logic [AW-1:0]  addr_q;
    logic [FCW-1:0] fc_q;
    logic [DW-1:0]  wdata_q;
    logic [BEW-1:0] ds_nx;
    logic           ds_phase;

    assign ds_phase = wr_q ? ph_wds_on(phase_nx) : ph_as_on(phase_nx);

    // One strobe per byte lane, gated by that lane's enable.
    for (genvar g = 0; g < BEW; g++) begin : g_lane
        assign ds_nx[g] = !(be_q[g] && ds_phase);
    end

    // Hold the request for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            be_q    <= '0;
            addr_q  <= '0;
            fc_q    <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            be_q    <= req_be;
            addr_q  <= req_addr;
            fc_q    <= req_fc;
            wdata_q <= req_wdata;
        end
    end

    // Address and function code become valid entering S1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr <= '0;
            bus_fc   <= '0;
        end else if (phase_nx == PH_S1) begin
            bus_addr <= addr_q;
            bus_fc   <= fc_q;
        end
    end

    // Strobes and direction, registered from the next half-state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_as_n <= 1'b1;
            bus_ds_n <= '1;
            bus_rw   <= 1'b1;
        end else begin
            bus_as_n <= !ph_as_on(phase_nx);
            bus_ds_n <= ds_nx;
            bus_rw   <= !(wr_q && ph_as_on(phase_nx));
        end
    end

    // Write data from S3, held one half-state past strobe negation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_dq_out <= '0;
            bus_dq_oe  <= 1'b0;
        end else begin
            if (wr_q && (phase_nx == PH_S3)) begin
                bus_dq_out <= wdata_q;
            end
            bus_dq_oe <= wr_q && (ph_dout_on(phase_nx) || (phase_q == PH_S7));
        end
    end

    // Read data sampled at the end of S6; zero for writes and errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (phase_q == PH_S6) begin
            rsp_rdata <= (wr_q || err_q) ? '0 : bus_din;
        end
    end

endmodule

// File: rtl/bus_async_master.sv
// Asynchronous bus cycle master. Takes one request at a time and runs it
// as an eight-half-state bus cycle, ended by a synchronized acknowledge
// or bus error. Assumes clk runs at twice the wanted bus clock rate and
// that bus_din is stable at the end of S6 once acknowledge is seen.
module bus_async_master
    import bam_pkg::*;
#(
    parameter int AW          = 24,
    parameter int DW          = 16,
    parameter int FCW         = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW/8-1:0]   req_be,
    input  logic [FCW-1:0]    req_fc,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DW-1:0]     rsp_rdata,
    output logic              bus_clk,
    output logic [AW-1:0]     bus_addr,
    output logic [FCW-1:0]    bus_fc,
    output logic              bus_as_n,
    output logic [DW/8-1:0]   bus_ds_n,
    output logic              bus_rw,
    output logic [DW-1:0]     bus_dq_out,
    output logic              bus_dq_oe,
    input  logic [DW-1:0]     bus_din,
    input  logic              bus_ack_n,
    input  logic              bus_berr_n
);

    localparam int BEW   = DW / 8;
    localparam int NTERM = 2;

    logic [NTERM-1:0] term_raw_n;
    logic [NTERM-1:0] term_sync_n;
    bam_phase_e       phase_q;
    bam_phase_e       phase_nx;
    logic             accept;
    logic             err_q;

    assign term_raw_n = {bus_berr_n, bus_ack_n};

    // One synchronizer per termination input.
    for (genvar t = 0; t < NTERM; t++) begin : g_term
        bam_sync #(
            .STAGES (SYNC_STAGES),
            .INIT   (1'b1)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (term_raw_n[t]),
            .q     (term_sync_n[t])
        );
    end

    bam_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .term_ack  (!term_sync_n[0]),
        .term_err  (!term_sync_n[1]),
        .phase_q   (phase_q),
        .phase_nx  (phase_nx),
        .req_ready (req_ready),
        .accept    (accept),
        .err_q     (err_q),
        .rsp_valid (rsp_valid),
        .bus_clk   (bus_clk)
    );

    bam_drive #(
        .AW  (AW),
        .DW  (DW),
        .FCW (FCW),
        .BEW (BEW)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_q    (phase_q),
        .phase_nx   (phase_nx),
        .accept     (accept),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_fc     (req_fc),
        .req_wdata  (req_wdata),
        .err_q      (err_q),
        .bus_din    (bus_din),
        .bus_addr   (bus_addr),
        .bus_fc     (bus_fc),
        .bus_as_n   (bus_as_n),
        .bus_ds_n   (bus_ds_n),
        .bus_rw     (bus_rw),
        .bus_dq_out (bus_dq_out),
        .bus_dq_oe  (bus_dq_oe),
        .rsp_rdata  (rsp_rdata)
    );

    assign rsp_err = err_q;

endmodule

// File: rtl/bam_chk.sv
// Protocol checker for bus_async_master, attached by bind below.
// Observes only top-level ports.
module bam_chk #(
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int FCW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_clk,
    input logic [AW-1:0]   bus_addr,
    input logic [FCW-1:0]  bus_fc,
    input logic            bus_as_n,
    input logic [DW/8-1:0] bus_ds_n,
    input logic            bus_rw,
    input logic            bus_dq_oe,
    input logic            rsp_valid
);

    // R2: bus clock inverts every fast cycle once out of reset.
    p_bclk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bus_clk != $past(bus_clk)));

    // R2: address strobe falls only in a high bus-clock phase.
    p_as_high_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as_n) |-> bus_clk);

    // R2: address and function code hold while the strobe stays low.
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && !$past(bus_as_n)) |-> ($stable(bus_addr) && $stable(bus_fc)));

    // R4: read/write line holds while the strobe stays low.
    p_rw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && !$past(bus_as_n)) |-> $stable(bus_rw));

    // R3: no data driven during a read.
    p_read_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rw && !bus_as_n) |-> !bus_dq_oe);

    // R4: write data already driven when data strobes fall.
    p_wdata_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_ds_n != '1) && ($past(bus_ds_n) == '1) && !bus_rw) |-> $past(bus_dq_oe));

    // R5: a data strobe is only active inside the address strobe.
    p_ds_inside_as_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ds_n != '1) |-> !bus_as_n);

    // R11: response coincides with the address strobe rising.
    p_rsp_at_as_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(bus_as_n));

    // R11: response is a single-cycle pulse.
    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind bus_async_master bam_chk #(
    .AW  (AW),
    .DW  (DW),
    .FCW (FCW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_clk   (bus_clk),
    .bus_addr  (bus_addr),
    .bus_fc    (bus_fc),
    .bus_as_n  (bus_as_n),
    .bus_ds_n  (bus_ds_n),
    .bus_rw    (bus_rw),
    .bus_dq_oe (bus_dq_oe),
    .rsp_valid (rsp_valid)
);

// File: tb/sim_bus_async_master.sv
// Self-checking bench: vector table of transfers walked by one loop,
// then a directed mid-transfer reset.
module sim_bus_async_master;

    typedef struct packed {
        logic        wr;
        logic [23:0] addr;
        logic [1:0]  be;
        logic [2:0]  fc;
        logic [15:0] data;
        logic [3:0]  dly;
        logic [1:0]  mode;   // 0 ack, 1 bus error, 2 both
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h123456, 2'b11, 3'd5, 16'hA55A, 4'd0, 2'd0},
        '{1'b1, 24'h00FFFE, 2'b11, 3'd1, 16'h1234, 4'd0, 2'd0},
        '{1'b0, 24'hABCDEF, 2'b10, 3'd6, 16'hBEEF, 4'd3, 2'd0},
        '{1'b1, 24'h800000, 2'b01, 3'd2, 16'h00C3, 4'd1, 2'd0},
        '{1'b0, 24'h000002, 2'b11, 3'd5, 16'h7777, 4'd2, 2'd1},
        '{1'b0, 24'h7FFFFF, 2'b10, 3'd1, 16'hF00F, 4'd0, 2'd2},
        '{1'b0, 24'h555554, 2'b00, 3'd5, 16'h1111, 4'd0, 2'd0},
        '{1'b0, 24'hFFFFFF, 2'b01, 3'd7, 16'h5A5A, 4'd5, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [23:0] req_addr;
    logic [1:0]  req_be;
    logic [2:0]  req_fc;
    logic [15:0] req_wdata;
    logic        rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic        bus_clk;
    logic [23:0] bus_addr;
    logic [2:0]  bus_fc;
    logic        bus_as_n;
    logic [1:0]  bus_ds_n;
    logic        bus_rw;
    logic [15:0] bus_dq_out;
    logic        bus_dq_oe;
    logic [15:0] bus_din;
    logic        bus_ack_n, bus_berr_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    bus_async_master u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_fc(req_fc), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_clk(bus_clk), .bus_addr(bus_addr), .bus_fc(bus_fc),
        .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_rw(bus_rw),
        .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe), .bus_din(bus_din),
        .bus_ack_n(bus_ack_n), .bus_berr_n(bus_berr_n)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Slave model: terminate sl_dly falling edges after the strobe is seen.
    int         sl_dly  = 0;
    logic [1:0] sl_mode = 2'd0;
    int         sl_cnt  = 0;
    always @(negedge clk) begin
        if (bus_as_n) begin
            bus_ack_n  = 1'b1;
            bus_berr_n = 1'b1;
            sl_cnt     = 0;
        end else begin
            if (sl_cnt == sl_dly) begin
                if (sl_mode != 2'd1) bus_ack_n  = 1'b0;
                if (sl_mode != 2'd0) bus_berr_n = 1'b0;
            end
            sl_cnt++;
        end
    end

    // Bus monitor: strobe ordering, address, data drive and gap.
    logic        exp_wr;
    logic [23:0] exp_addr;
    logic [1:0]  exp_be;
    logic [2:0]  exp_fc;
    logic [15:0] exp_data;
    bit prev_as = 1, first_xfer = 1, ds_seen = 0, hold_pend = 0;
    int fall_cyc = 0, high_run = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_as   = 1;
            hold_pend = 0;
            high_run  = 0;
        end else begin
            if (hold_pend) begin
                chk(!bus_dq_oe, "R4 data released after hold", bus_dq_oe, 0);
                hold_pend = 0;
            end
            if (prev_as && !bus_as_n) begin
                chk(bus_clk, "R2 strobe in high phase", bus_clk, 1);
                chk(bus_addr == exp_addr, "R2 address", bus_addr, exp_addr);
                chk(bus_fc == exp_fc, "R2 function code", bus_fc, exp_fc);
                if (!first_xfer) chk(high_run >= 2, "R10 negated gap", high_run, 2);
                first_xfer = 0;
                if (exp_wr) begin
                    chk(!bus_rw, "R4 rw low with strobe", bus_rw, 0);
                    chk(bus_ds_n == 2'b11, "R4 no data strobe yet", bus_ds_n, 2'b11);
                end else begin
                    chk(bus_rw, "R3 rw high on read", bus_rw, 1);
                    chk(bus_ds_n == ~exp_be, "R3 R5 read strobes", bus_ds_n, ~exp_be);
                    chk(!bus_dq_oe, "R3 bus released on read", bus_dq_oe, 0);
                end
                fall_cyc = cyc;
                ds_seen  = 0;
            end
            if (!bus_as_n && (bus_ds_n != 2'b11) && !ds_seen) begin
                ds_seen = 1;
                chk(bus_ds_n == ~exp_be, "R5 strobe lanes", bus_ds_n, ~exp_be);
                if (exp_wr) begin
                    chk(cyc == fall_cyc + 2, "R4 strobe delay", cyc - fall_cyc, 2);
                    chk(bus_dq_oe && (bus_dq_out == exp_data), "R4 data before strobe",
                        bus_dq_out, exp_data);
                end
            end
            if (!prev_as && bus_as_n) begin
                if (exp_wr) begin
                    chk(bus_dq_oe, "R4 data held past strobe", bus_dq_oe, 1);
                    hold_pend = 1;
                end
                if (exp_be == 2'b00) chk(!ds_seen, "R5 zero enables no strobe", ds_seen, 0);
            end
            high_run = bus_as_n ? high_run + 1 : 0;
            prev_as  = bus_as_n;
        end
    end

    task automatic run_vec(input vec_t v);
        int acc;
        int lat;
        int exp_lat;
        logic [15:0] exp_rd;
        exp_wr = v.wr; exp_addr = v.addr; exp_be = v.be; exp_fc = v.fc; exp_data = v.data;
        sl_dly = int'(v.dly); sl_mode = v.mode;
        bus_din   = v.data;
        req_write = v.wr; req_addr = v.addr; req_be = v.be;
        req_fc    = v.fc; req_wdata = v.data;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R10 busy during transfer", req_ready, 0);
        while (!rsp_valid) @(negedge clk);
        lat     = cyc - acc;
        exp_lat = 8 + 2 * ((int'(v.dly) + 1) / 2);
        chk(lat == exp_lat, "R6 completion latency", lat, exp_lat);
        exp_rd = (v.wr || v.mode != 2'd0) ? 16'h0 : v.data;
        if (v.mode == 2'd2) begin
            chk(rsp_err, "R9 error wins over acknowledge", rsp_err, 1);
            chk(rsp_rdata == 16'h0, "R9 no data on error", rsp_rdata, 0);
        end else if (v.mode == 2'd1) begin
            chk(rsp_err, "R8 bus error flag", rsp_err, 1);
            chk(rsp_rdata == 16'h0, "R8 no data on error", rsp_rdata, 0);
        end else begin
            chk(!rsp_err, "R7 no error", rsp_err, 0);
            chk(rsp_rdata == exp_rd, "R7 read data", rsp_rdata, exp_rd);
        end
        @(negedge clk);
        chk(!rsp_valid, "R11 single pulse", rsp_valid, 0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_be = '0; req_fc = '0; req_wdata = '0; bus_din = '0;
        bus_ack_n = 1'b1; bus_berr_n = 1'b1;
        exp_wr = 0; exp_addr = '0; exp_be = '0; exp_fc = '0; exp_data = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(bus_as_n && bus_ds_n == 2'b11 && bus_rw && !bus_dq_oe && !rsp_valid,
            "R1 reset state", {bus_as_n, bus_ds_n, bus_rw, bus_dq_oe, rsp_valid}, 6'b111100);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // Directed: reset taken while a write holds the bus (R1).
        exp_wr = 1; exp_addr = 24'h0A0A0A; exp_be = 2'b11; exp_fc = 3'd2; exp_data = 16'hCAFE;
        sl_dly = 15; sl_mode = 2'd0;
        req_write = 1'b1; req_addr = 24'h0A0A0A; req_be = 2'b11; req_fc = 3'd2;
        req_wdata = 16'hCAFE; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (bus_ds_n == 2'b11) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(bus_as_n && bus_ds_n == 2'b11 && bus_rw && !bus_dq_oe && !rsp_valid,
            "R1 reset mid transfer", {bus_as_n, bus_ds_n, bus_rw, bus_dq_oe, rsp_valid}, 6'b111100);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(bus_as_n && !rsp_valid, "R1 idle after reset", {bus_as_n, rsp_valid}, 2'b10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule